// File: doc/BRIEF.md
# Weighted Round-Robin Bus Arbiter

This block decides which of several bridge units may drive a shared 8-bit internal bus in each cycle. Every unit raises a request line and offers one data byte and a 3-bit destination tag. The arbiter asserts a single grant and places the winner's byte and tag on the shared bus, together with a valid strobe in that same cycle.

Each unit has a 4-bit weight that sets how many consecutive cycles it may keep the bus while it keeps requesting. When a burst ends, either because the weight is used up or because the unit dropped its request, the search for the next owner starts at the index after the last owner and wraps around. Because of this rotation, a unit that keeps requesting is always served within a bounded number of cycles. Bandwidth is therefore shared in proportion to the weights and no unit can be starved.

Grant selection is combinational from registered arbitration state and the current requests. A unit that lowers its request loses the bus in that same cycle.

Top module: `wrr_bus_arbiter`

## Requirements
- R1: At most one bit of `grant_o` is high in any cycle, and `grant_o` is all zero in every cycle in which no `req_i` bit is high.
- R2: A grant bit is only high in a cycle in which the same unit's `req_i` bit is high.
- R3: When unit i is granted, `bus_valid_o` is 1 and `bus_data_o`/`bus_tag_o` equal lane i of `req_data_i` (bits i*8 upward) and `req_tag_i` (bits i*3 upward) in that same cycle. With no grant, `bus_valid_o`, `bus_data_o` and `bus_tag_o` are all 0.
- R4: A granted unit that keeps requesting holds the grant for exactly its weight (lane i of `weight_i`, bits i*4 upward) in consecutive cycles. It then loses the grant if any other unit requests.
- R5: A weight of 0 gives the same one-cycle burst as a weight of 1.
- R6: When a burst ends, the next grant goes to the first requesting unit found by scanning upward from the index after the previous owner, wrapping from N_REQ-1 to 0.
- R7: In the first cycle in which the owning unit's request is low, the grant moves to the next requesting unit in rotation order, without an idle cycle.
- R8: After reset, the scan for the first grant starts at index 0.
- R9: A unit that requests continuously receives a grant within N_REQ*2^WGT_W cycles. With all weights at 15 and all eight units requesting, unit 7 is first granted in cycle 106 after reset.
- R10: A sole requester is granted in every cycle, also across burst boundaries, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_REQ | Bus request, one bit per unit |
| req_data_i | input | N_REQ*DATA_W | Data byte offered by each unit |
| req_tag_i | input | N_REQ*TAG_W | Destination tag offered by each unit |
| weight_i | input | N_REQ*WGT_W | Burst weight per unit (0 treated as 1) |
| grant_o | output | N_REQ | One-hot grant |
| bus_valid_o | output | 1 | Shared bus carries a valid word this cycle |
| bus_data_o | output | DATA_W | Shared bus data |
| bus_tag_o | output | TAG_W | Shared bus destination tag |

## Verification
The bench checks mixed weights, where an off-by-one burst counter would hand out one cycle too many or too few. It drops the owner's request in mid-burst, where a registered grant would leave an idle or stale cycle. It sets weights to zero, where a design without clamping would skip the unit or stall on it. It runs a single requester across burst boundaries, where a design that rescans badly would insert gaps. A full-load run with maximum weights pins the exact cycle in which the highest index is first served. Any rotation pointer that restarts at zero instead of after the last owner shifts that cycle.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
   // Effective burst length: a zero weight still grants one cycle.
   function automatic logic [7:0] eff_weight(input logic [7:0] w);
      return (w == 8'd0) ? 8'd1 : w;
   endfunction
endpackage

// File: rtl/wrr_rr_pick.sv
module wrr_rr_pick #(
   parameter int N_REQ = 8,
   parameter int IDX_W = $clog2(N_REQ)
) (
   input  logic [N_REQ-1:0] req_i,
   input  logic [IDX_W-1:0] start_i,
   output logic             found_o,
   output logic [IDX_W-1:0] sel_o
);
   int idx;

   always_comb begin
      found_o = 1'b0;
      sel_o   = '0;
      idx     = 0;
      for (int k = 0; k < N_REQ; k++) begin
         idx = int'(start_i) + k;
         if (idx >= N_REQ) idx = idx - N_REQ;
         if (!found_o && req_i[idx]) begin
            found_o = 1'b1;
            sel_o   = IDX_W'(idx);
         end
      end
   end
endmodule

// File: rtl/wrr_burst_ctrl.sv
module wrr_burst_ctrl
   import wrr_pkg::*;
#(
   parameter int N_REQ = 8,
   parameter int WGT_W = 4,
   parameter int IDX_W = $clog2(N_REQ)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_REQ-1:0]       req_i,
   input  logic [N_REQ*WGT_W-1:0] weight_i,
   input  logic                   found_i,
   input  logic [IDX_W-1:0]       sel_i,
   output logic                   hold_o,
   output logic [IDX_W-1:0]       owner_o,
   output logic [IDX_W-1:0]       start_o
);
   logic             busy_q;
   logic [IDX_W-1:0] owner_q;
   logic [IDX_W-1:0] ptr_q;
   logic [WGT_W-1:0] cnt_q;
   logic [WGT_W-1:0] w_raw;
   logic [WGT_W-1:0] w_eff;
   logic             owner_req;

   always_comb begin
      w_raw     = '0;
      owner_req = 1'b0;
      for (int i = 0; i < N_REQ; i++) begin
         if (owner_q == IDX_W'(i)) begin
            w_raw     = weight_i[i*WGT_W +: WGT_W];
            owner_req = req_i[i];
         end
      end
      w_eff  = WGT_W'(eff_weight(8'(w_raw)));
      hold_o = busy_q && owner_req && (cnt_q < w_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         owner_q <= '0;
         ptr_q   <= '0;
         cnt_q   <= '0;
      end else if (hold_o) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (found_i) begin
         busy_q  <= 1'b1;
         owner_q <= sel_i;
         cnt_q   <= WGT_W'(1);
         ptr_q   <= (sel_i == IDX_W'(N_REQ-1)) ? '0 : sel_i + 1'b1;
      end else begin
         busy_q <= 1'b0;
      end
   end

   assign owner_o = owner_q;
   assign start_o = ptr_q;

   AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q >= WGT_W'(1) && cnt_q <= w_eff)); // R4
   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      hold_o |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
   AST_ZERO_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && w_raw == '0) |-> (cnt_q == WGT_W'(1))); // R5
endmodule

// File: rtl/wrr_bus_mux.sv
module wrr_bus_mux #(
   parameter int N_REQ     = 8,
   parameter int DATA_W    = 8,
   parameter int TAG_W     = 3,
   parameter bit ZERO_IDLE = 1'b1,
   parameter int IDX_W     = $clog2(N_REQ)
) (
   input  logic                    gnt_vld_i,
   input  logic [IDX_W-1:0]        gnt_idx_i,
   input  logic [N_REQ*DATA_W-1:0] data_i,
   input  logic [N_REQ*TAG_W-1:0]  tag_i,
   output logic                    valid_o,
   output logic [DATA_W-1:0]       data_o,
   output logic [TAG_W-1:0]        tag_o
);
   logic [DATA_W-1:0] d_sel;
   logic [TAG_W-1:0]  t_sel;

   always_comb begin
      d_sel = '0;
      t_sel = '0;
      for (int i = 0; i < N_REQ; i++) begin
         if (gnt_idx_i == IDX_W'(i)) begin
            d_sel = data_i[i*DATA_W +: DATA_W];
            t_sel = tag_i[i*TAG_W +: TAG_W];
         end
      end
   end

   assign valid_o = gnt_vld_i;

   generate
      if (ZERO_IDLE) begin : g_zero_idle
         assign data_o = gnt_vld_i ? d_sel : '0;
         assign tag_o  = gnt_vld_i ? t_sel : '0;
      end else begin : g_pass_idle
         assign data_o = d_sel;
         assign tag_o  = t_sel;
      end
   endgenerate
endmodule

// File: rtl/wrr_bus_arbiter.sv
module wrr_bus_arbiter #(
   parameter int N_REQ     = 8,
   parameter int DATA_W    = 8,
   parameter int TAG_W     = 3,
   parameter int WGT_W     = 4,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_REQ-1:0]        req_i,
   input  logic [N_REQ*DATA_W-1:0] req_data_i,
   input  logic [N_REQ*TAG_W-1:0]  req_tag_i,
   input  logic [N_REQ*WGT_W-1:0]  weight_i,
   output logic [N_REQ-1:0]        grant_o,
   output logic                    bus_valid_o,
   output logic [DATA_W-1:0]       bus_data_o,
   output logic [TAG_W-1:0]        bus_tag_o
);
   localparam int IDX_W      = $clog2(N_REQ);
   localparam int STARVE_MAX = N_REQ * (2 ** WGT_W);
   localparam int SW         = $clog2(STARVE_MAX + 1);

   generate
      if (N_REQ < 2 || N_REQ > 2 ** TAG_W) begin : g_bad_nreq
         $error("N_REQ must lie between 2 and 2**TAG_W");
      end
      if (WGT_W < 1 || WGT_W > 8) begin : g_bad_wgt
         $error("WGT_W must lie between 1 and 8");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic             hold;
   logic             found;
   logic [IDX_W-1:0] owner;
   logic [IDX_W-1:0] start;
   logic [IDX_W-1:0] sel;
   logic             gnt_vld;
   logic [IDX_W-1:0] gnt_idx;

   wrr_rr_pick #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_pick (
      .req_i   (req_i),
      .start_i (start),
      .found_o (found),
      .sel_o   (sel)
   );

   wrr_burst_ctrl #(.N_REQ(N_REQ), .WGT_W(WGT_W), .IDX_W(IDX_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .weight_i (weight_i),
      .found_i  (found),
      .sel_i    (sel),
      .hold_o   (hold),
      .owner_o  (owner),
      .start_o  (start)
   );

   assign gnt_vld = hold | found;
   assign gnt_idx = hold ? owner : sel;

   genvar g;
   generate
      for (g = 0; g < N_REQ; g++) begin : g_lane
         logic [SW-1:0] wait_q;

         assign grant_o[g] = gnt_vld && (gnt_idx == IDX_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      wait_q <= '0;
            else if (req_i[g] && !grant_o[g]) wait_q <= wait_q + 1'b1;
            else                             wait_q <= '0;
         end

         AST_NO_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q < SW'(STARVE_MAX)); // R9
      end
   endgenerate

   wrr_bus_mux #(
      .N_REQ(N_REQ), .DATA_W(DATA_W), .TAG_W(TAG_W),
      .ZERO_IDLE(ZERO_IDLE), .IDX_W(IDX_W)
   ) u_mux (
      .gnt_vld_i (gnt_vld),
      .gnt_idx_i (gnt_idx),
      .data_i    (req_data_i),
      .tag_i     (req_tag_i),
      .valid_o   (bus_valid_o),
      .data_o    (bus_data_o),
      .tag_o     (bus_tag_o)
   );

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o)); // R1
   AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == '0) |-> (grant_o == '0)); // R1
   AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & ~req_i) == '0); // R2
   AST_VALID_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid_o == (grant_o != '0)); // R3
   AST_SOLE_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($onehot(req_i) && $stable(req_i)) |-> (grant_o == req_i)); // R10
endmodule

// File: tb/tb_wrr_bus_arbiter.sv
module tb_wrr_bus_arbiter;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N*8-1:0] data;
   logic [N*3-1:0] tag;
   logic [N*4-1:0] weight = '0;
   logic [N-1:0] grant;
   logic         valid;
   logic [7:0]   bdata;
   logic [2:0]   btag;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   wrr_bus_arbiter dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_data_i(data),
      .req_tag_i(tag), .weight_i(weight), .grant_o(grant),
      .bus_valid_o(valid), .bus_data_o(bdata), .bus_tag_o(btag)
   );

   task automatic set_w(input int i, input int w);
      weight[i*4 +: 4] = 4'(w);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req   = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Drive requests for one cycle and check outputs; exp < 0 means no grant.
   task automatic step(input logic [N-1:0] r, input int exp, input string rq);
      logic [N-1:0] eg;
      logic         ev;
      logic [7:0]   ed;
      logic [2:0]   et;
      @(negedge clk);
      req = r;
      #1;
      eg = (exp < 0) ? '0 : (N'(1) << exp);
      ev = (exp >= 0);
      ed = (exp < 0) ? 8'h00 : 8'(8'hA0 + exp);
      et = (exp < 0) ? 3'd0 : 3'(7 - exp);
      n_checks++;
      if (grant !== eg || valid !== ev || bdata !== ed || btag !== et ||
          (grant & ~req) != '0) begin
         n_fail++;
         $display("FAIL %s: grant=%b valid=%b data=%h tag=%h expected grant=%b valid=%b data=%h tag=%h",
                  rq, grant, valid, bdata, btag, eg, ev, ed, et);
      end
   endtask

   task automatic t_reset_idle();
      weight = {N{4'd1}};
      do_reset();
      step('0, -1, "R1 reset idle");
      step('0, -1, "R3 idle bus zero");
   endtask

   task automatic t_plain_rotation();
      weight = {N{4'd1}};
      do_reset();
      for (int k = 0; k < 9; k++) step('1, k % N, "R8 R6 rotation");
   endtask

   task automatic t_weights();
      weight = {N{4'd1}};
      set_w(0, 2); set_w(1, 1); set_w(2, 3);
      do_reset();
      step(8'b0000_0111, 0, "R4 w2 first");
      step(8'b0000_0111, 0, "R4 w2 second");
      step(8'b0000_0111, 1, "R4 w1");
      step(8'b0000_0111, 2, "R4 w3 a");
      step(8'b0000_0111, 2, "R4 w3 b");
      step(8'b0000_0111, 2, "R4 w3 c");
      step(8'b0000_0111, 0, "R6 wrap");
      step(8'b0000_0111, 0, "R4 again");
   endtask

   task automatic t_zero_weight();
      weight = {N{4'd4}};
      set_w(3, 0); set_w(5, 0);
      do_reset();
      step(8'b0010_1000, 3, "R5 zero weight 3");
      step(8'b0010_1000, 5, "R5 zero weight 5");
      step(8'b0010_1000, 3, "R5 zero weight 3b");
      step(8'b0010_1000, 5, "R5 zero weight 5b");
   endtask

   task automatic t_early_drop();
      weight = {N{4'd4}};
      do_reset();
      step(8'b0000_0011, 0, "R7 owner");
      step(8'b0000_0011, 0, "R7 owner hold");
      step(8'b0000_0010, 1, "R7 drop moves now");
      step(8'b0000_0010, 1, "R4 burst 2");
      step(8'b0000_0010, 1, "R4 burst 3");
      step(8'b0000_0010, 1, "R4 burst 4");
      step(8'b0000_0010, 1, "R10 rescan sole");
      step(8'b0000_0000, -1, "R1 all drop");
   endtask

   task automatic t_sole();
      weight = {N{4'd1}};
      set_w(6, 2);
      do_reset();
      for (int k = 0; k < 5; k++) step(8'b0100_0000, 6, "R10 sole requester");
      step(8'b0000_0000, -1, "R2 released");
   endtask

   task automatic t_starve();
      weight = {N{4'd15}};
      do_reset();
      for (int k = 0; k < 105; k++) step('1, k / 15, "R9 full load");
      step('1, 7, "R9 last index served");
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         data[i*8 +: 8] = 8'(8'hA0 + i);
         tag[i*3 +: 3]  = 3'(7 - i);
      end
      t_reset_idle();
      t_plain_rotation();
      t_weights();
      t_zero_weight();
      t_early_drop();
      t_sole();
      t_starve();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule